// File: doc/BRIEF.md
# Interrupt Summary Combiner

This block collects a parameterised number of level-sensitive interrupt lines and folds them into a single summary request for a parent interrupt controller. Every line first passes through a two-stage synchroniser. The synchronised levels feed both a registered OR, which drives the summary output, and a bank of 32-bit read-only status words. Interrupt handlers read these words to find out which sources are active.

Line n is reported at bit (n mod 32) of status word (n div 32). When the line count is not a multiple of 32, the last word is only partly populated. The block has no mask, no latch and no edge detector. A status bit shows the present level of its line, and a source holds its request until it is serviced. Software keeps any enable state of its own.

The read port is a single-cycle strobe with a word index. The selected word is returned one clock later, and a read changes no state.

Top module: `irq_aggregator`

## Requirements
- R1: The summary output `irq_out` equals the OR of all synchronised line levels, registered once, so it is high exactly when at least one line was high in the synchronised state one clock earlier.
- R2: A change on `irq_in` reaches `irq_out` at the third rising clock edge after it is applied: two edges of synchronisation and one edge of summary register. It has not reached `irq_out` after the second edge.
- R3: Line n appears at bit (n mod 32) of status word index (n div 32).
- R4: Bits of the last status word above the populated width (above bit NUM_SRC-32*(words-1)-1) always read as zero.
- R5: A read with an index at or beyond the number of status words returns all zeros.
- R6: Reads have no side effect. Repeated reads of the same word return the same value while the inputs are steady, and `irq_out` is unaffected by reads.
- R7: While `rst_n` is low, and directly after reset, `irq_out` is 0 and `rd_data` is 0.
- R8: When `rd_en` is low, `rd_data` holds its previous value.
- R9: Status bits are not sticky. A line that drops reads as 0 once the drop has passed the synchroniser, and `irq_out` falls when no line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_SRC | Level-sensitive interrupt lines, asynchronous to clk |
| irq_out | output | 1 | Registered OR of all synchronised lines |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_idx | input | IDX_W | Status word index |
| rd_data | output | 32 | Status word, valid the clock after the strobe |

## Verification
A status read and a change of the summary output can land on the same clock edge. Both then draw on the same synchronised levels, so they must agree. The bench raises a single line and issues the read so that it is captured on the edge at which `irq_out` rises. It then checks that, in that cycle, the returned word already carries the line's bit and the summary is high. A second case reads while the last line drops, so that the word and the summary must fall together.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int WORD_W     = 32;
   localparam int SYNC_DEPTH = 2;

   function automatic int words_for(input int n);
      return (n + WORD_W - 1) / WORD_W;
   endfunction
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqagg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("irqagg_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic         any_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) any_q <= 1'b0;
      else        any_q <= |lvl;
   end

   // R1: summary is the OR of the synchronised levels of the previous cycle
   assert_or_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      any_q == |$past(lvl));
endmodule

// File: rtl/irqagg_status_bank.sv
module irqagg_status_bank
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC = 40,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lvl,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [WORD_W-1:0]  rd_data
);
   localparam int NUM_REGS = words_for(NUM_SRC);
   localparam int PAD_W    = NUM_REGS * WORD_W - NUM_SRC;
   localparam int TAIL_W   = NUM_SRC - (NUM_REGS - 1) * WORD_W;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("irqagg_status_bank: NUM_SRC must be positive");
   end
   if ((1 << IDX_W) < NUM_REGS) begin : g_bad_idx
      $error("irqagg_status_bank: IDX_W too narrow for the word count");
   end

   logic [NUM_REGS*WORD_W-1:0] flat;
   logic [WORD_W-1:0]          words [NUM_REGS];
   logic [WORD_W-1:0]          sel;

   if (PAD_W == 0) begin : g_full
      assign flat = lvl;
   end else begin : g_pad
      assign flat = {{PAD_W{1'b0}}, lvl};
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      assign words[g] = flat[g*WORD_W +: WORD_W];
   end

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_idx == IDX_W'(i)) sel = words[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel;
   end

   // R5: out-of-range index returns zero
   assert_oob_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (int'(rd_idx) >= NUM_REGS)) |=> (rd_data == '0));

   // R8: no strobe, no change
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   if (PAD_W > 0) begin : g_pad_chk
      // R4: unpopulated bits of the last word stay zero
      assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && (int'(rd_idx) == NUM_REGS - 1)) |=> ((rd_data >> TAIL_W) == '0));
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC = 40,
   parameter int IDX_W   = $clog2(words_for(NUM_SRC)) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   output logic               irq_out,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [WORD_W-1:0]  rd_data
);
   localparam int LAT = SYNC_DEPTH + 1;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_aggregator: NUM_SRC must be positive");
   end

   logic [NUM_SRC-1:0] lvl;

   irqagg_sync #(.W(NUM_SRC), .STAGES(SYNC_DEPTH)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (irq_in),
      .q_sync  (lvl)
   );

   irqagg_summary #(.W(NUM_SRC)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .any_q (irq_out)
   );

   irqagg_status_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   // cycles since reset, saturating, so the latency check never looks before reset
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R2: three edges from input to summary
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(since_rst) >= LAT) |-> (irq_out == |$past(irq_in, 3)));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
   localparam int N   = 40;
   localparam int IW  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          irq_out;
   logic          rd_en = 1'b0;
   logic [IW-1:0] rd_idx = '0;
   logic [31:0]   rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_aggregator #(.NUM_SRC(N), .IDX_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_word(input logic [N-1:0] src, input int idx);
      logic [31:0] w = '0;
      for (int b = 0; b < 32; b++)
         if (idx * 32 + b < N) w[b] = src[idx*32 + b];
      return w;
   endfunction

   task automatic set_in(input logic [N-1:0] v);
      @(negedge clk) irq_in = v;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(input int idx, output logic [31:0] v);
      @(negedge clk); rd_en = 1'b1; rd_idx = IW'(idx);
      @(negedge clk); v = rd_data; rd_en = 1'b0;
   endtask

   task automatic t_reset();
      chk(irq_out == 1'b0, "R7 summary in reset", {31'b0, irq_out}, 32'h0);
      chk(rd_data == '0, "R7 data in reset", rd_data, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(irq_out == 1'b0, "R7 summary after reset", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_bitmap();
      logic [31:0] v;
      int lines[4] = '{0, 31, 32, 39};
      foreach (lines[k]) begin
         logic [N-1:0] s = '0;
         s[lines[k]] = 1'b1;
         set_in(s); settle();
         for (int w = 0; w < 2; w++) begin
            rd(w, v);
            chk(v == model_word(s, w), "R3 bit position", v, model_word(s, w));
         end
         chk(irq_out == 1'b1, "R1 single line", {31'b0, irq_out}, 32'h1);
      end
   endtask

   task automatic t_or();
      logic [N-1:0] pats[3] = '{40'h0, 40'hA5_0000_3C01, 40'h80_0000_0000};
      foreach (pats[k]) begin
         set_in(pats[k]); settle();
         chk(irq_out == (|pats[k]), "R1 OR of lines", {31'b0, irq_out}, {31'b0, |pats[k]});
      end
   endtask

   task automatic t_latency();
      set_in('0); settle();
      set_in(40'h1_0000_0000);
      @(negedge clk); @(negedge clk);
      chk(irq_out == 1'b0, "R2 not yet after two edges", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
      chk(irq_out == 1'b1, "R2 set at third edge", {31'b0, irq_out}, 32'h1);
   endtask

   task automatic t_pad_oob();
      logic [31:0] v;
      set_in('1); settle();
      rd(1, v);
      chk(v == 32'h0000_00FF, "R4 pad bits zero", v, 32'h0000_00FF);
      rd(0, v);
      chk(v == 32'hFFFF_FFFF, "R3 full word", v, 32'hFFFF_FFFF);
      rd(2, v);
      chk(v == 32'h0, "R5 index 2", v, 32'h0);
      rd(3, v);
      chk(v == 32'h0, "R5 index 3", v, 32'h0);
   endtask

   task automatic t_noside();
      logic [31:0] a, b;
      set_in(40'h12_3456_789A); settle();
      rd(0, a); rd(0, b);
      chk(a == b && a == 32'h3456_789A, "R6 repeat read", b, 32'h3456_789A);
      chk(irq_out == 1'b1, "R6 summary kept", {31'b0, irq_out}, 32'h1);
      rd(1, a);
      chk(a == 32'h12, "R6 other word", a, 32'h12);
      // R8: no strobe, value holds while inputs move
      set_in('0); settle();
      chk(rd_data == 32'h12, "R8 hold without strobe", rd_data, 32'h12);
   endtask

   task automatic t_level();
      logic [31:0] v;
      set_in(40'h00_0000_0004); settle();
      set_in('0); settle();
      rd(0, v);
      chk(v == 32'h0, "R9 not sticky", v, 32'h0);
      chk(irq_out == 1'b0, "R9 summary falls", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_same_cycle();
      set_in('0); settle();
      set_in(40'h20);
      @(negedge clk);
      @(negedge clk); rd_en = 1'b1; rd_idx = '0;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_data == 32'h20, "R3 read on summary edge", rd_data, 32'h20);
      chk(irq_out == 1'b1, "R1 summary on read edge", {31'b0, irq_out}, 32'h1);
      set_in('0);
      @(negedge clk);
      @(negedge clk); rd_en = 1'b1; rd_idx = '0;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_data == 32'h0, "R9 read on falling edge", rd_data, 32'h0);
      chk(irq_out == 1'b0, "R9 summary on read edge", {31'b0, irq_out}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_bitmap();
      t_or();
      t_latency();
      t_pad_oob();
      t_noside();
      t_level();
      t_same_cycle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule